// File: doc/BRIEF.md
# Audio Activity Flag with Programmable Release Delay

This block watches a stereo stream of signed samples and raises a single activity flag when sound is present. A channel counts as active when the absolute value of its sample is strictly larger than an unsigned threshold. The flag rises only after activity has lasted without a break for one second. It falls only after silence has lasted for a delay chosen by a 3-bit code. Code zero releases the flag at once. The other codes give 60 s to 240 s in 30 s steps.

Time is measured in ticks from an external `tick` strobe. The parameter `TICKS_PER_SEC` says how many ticks make one second, so a bench can run with a very short second. The flag may be tied straight to an active-low standby input, so a long silence puts the downstream volume stage into standby.

Top module: `audio_activity_flag`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `flag` is 0.
- R2: Audio is present in a cycle when, for at least one of `left_smp`/`right_smp` (two's complement), the absolute value is strictly greater than `threshold` (unsigned). A sample equal to the threshold is silence. The most negative sample value has magnitude 2^(W-1).
- R3: With `flag` low, `flag` goes high in the cycle after the `TICKS_PER_SEC`-th tick that is seen while audio is present in every cycle since the run of presence began.
- R4: With `flag` low, any cycle without audio discards the ticks already counted toward R3, and `flag` stays low in the next cycle.
- R5: With `flag` high and `delay_code` = c in 1..7, `flag` goes low in the cycle after the ((c+1)*30*`TICKS_PER_SEC`)-th tick seen during an unbroken run of silent cycles.
- R6: With `flag` high and `delay_code` = 0, the first silent cycle makes `flag` low in the next cycle.
- R7: With `flag` high, a cycle with audio present discards the release count, and `flag` stays high in the next cycle.
- R8: Only cycles with `tick` high advance either count. Any number of cycles without `tick` neither raises nor releases the flag, except as R6 states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe, `TICKS_PER_SEC` per second |
| left_smp | input | W | Left sample, signed |
| right_smp | input | W | Right sample, signed |
| threshold | input | W | Unsigned detection level |
| delay_code | input | 3 | Release delay selector |
| flag | output | 1 | Activity flag, registered |

## Verification
The assertions assume that `delay_code` does not change while a release countdown is running. A change in that window could move the terminal count below the value already counted. The stimulus therefore picks a new code only at the start of an active burst, when the release count is cleared. The assertions also assume `tick` is a plain strobe that may be high in consecutive cycles. The stimulus drives it either every cycle or at random, and covers long runs with no tick at all.

// File: rtl/aaf_pkg.sv
package aaf_pkg;

    typedef enum logic [1:0] {
        PH_QUIET = 2'd0,
        PH_ARM   = 2'd1,
        PH_LIVE  = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    typedef struct packed {
        logic clear;
        logic step;
        logic sel_hold;
    } cnt_ctrl_t;

    localparam int QUAL_SEC     = 1;
    localparam int HOLD_STEP    = 30;
    localparam int HOLD_MAX_SEC = 240;

    function automatic int hold_seconds(input logic [2:0] code);
        return (code == 3'd0) ? 0 : (int'(code) + 1) * HOLD_STEP;
    endfunction

endpackage

// File: rtl/aaf_channel_mag.sv
module aaf_channel_mag #(
    parameter int W = 16
) (
    input  logic [W-1:0] smp,
    input  logic [W-1:0] thr,
    output logic         above
);
    logic [W-1:0] mag;

    always_comb begin
        if (smp[W-1]) mag = ~smp + 1'b1;
        else          mag = smp;
        above = (mag > thr);
    end

endmodule

// File: rtl/aaf_presence.sv
module aaf_presence #(
    parameter int W   = 16,
    parameter int NCH = 2
) (
    input  logic [NCH-1:0][W-1:0] smps,
    input  logic [W-1:0]          thr,
    output logic                  present
);
    logic [NCH-1:0] hits;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        aaf_channel_mag #(.W(W)) u_mag (
            .smp  (smps[g]),
            .thr  (thr),
            .above(hits[g])
        );
    end

    assign present = |hits;

endmodule

// File: rtl/aaf_window_sel.sv
module aaf_window_sel
    import aaf_pkg::*;
#(
    parameter int TPS = 4,
    parameter int CW  = 10
) (
    input  logic [2:0]    code,
    input  logic          sel_hold,
    output logic [CW-1:0] limit,
    output logic          zero_delay
);
    localparam int QUAL_TICKS = QUAL_SEC * TPS;

    always_comb begin
        zero_delay = (code == 3'd0);
        if (sel_hold) limit = CW'(hold_seconds(code) * TPS);
        else          limit = CW'(QUAL_TICKS);
    end

endmodule

// File: rtl/aaf_tick_counter.sv
module aaf_tick_counter #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt;

    assign hit = step && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (step) begin
            if (hit) cnt <= '0;
            else     cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/audio_activity_flag.sv
module audio_activity_flag
    import aaf_pkg::*;
#(
    parameter int W   = 16,
    parameter int TPS = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] left_smp,
    input  logic [W-1:0] right_smp,
    input  logic [W-1:0] threshold,
    input  logic [2:0]   delay_code,
    output logic         flag
);
    localparam int NCH = 2;
    localparam int CW  = $clog2(HOLD_MAX_SEC * TPS + 1);

    logic [NCH-1:0][W-1:0] smps;
    logic                  present;
    logic [CW-1:0]         limit;
    logic                  zero_delay;
    logic                  hit;
    logic                  flag_nxt;
    phase_e                phase;
    cnt_ctrl_t             ctl;

    assign smps[0] = left_smp;
    assign smps[1] = right_smp;

    aaf_presence #(.W(W), .NCH(NCH)) u_pres (
        .smps   (smps),
        .thr    (threshold),
        .present(present)
    );

    aaf_window_sel #(.TPS(TPS), .CW(CW)) u_win (
        .code      (delay_code),
        .sel_hold  (ctl.sel_hold),
        .limit     (limit),
        .zero_delay(zero_delay)
    );

    aaf_tick_counter #(.CW(CW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clear(ctl.clear),
        .step (ctl.step),
        .limit(limit),
        .hit  (hit)
    );

    always_comb begin
        case ({flag, present})
            2'b00:   phase = PH_QUIET;
            2'b01:   phase = PH_ARM;
            2'b11:   phase = PH_LIVE;
            default: phase = PH_HOLD;
        endcase
    end

    always_comb begin
        flag_nxt = flag;
        case (phase)
            PH_ARM:  if (hit) flag_nxt = 1'b1;
            PH_HOLD: if (zero_delay || hit) flag_nxt = 1'b0;
            default: flag_nxt = flag;
        endcase
        ctl.sel_hold = flag;
        ctl.step     = tick && ((phase == PH_ARM) ||
                                ((phase == PH_HOLD) && !zero_delay));
        ctl.clear    = (phase == PH_QUIET) || (phase == PH_LIVE) ||
                       (flag_nxt != flag);
    end

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= flag_nxt;
    end

endmodule

// File: rtl/audio_activity_flag_chk.sv
module audio_activity_flag_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [2:0] delay_code,
    input logic       present,
    input logic       flag
);
    assert_rise_needs_presence_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(present));

    assert_rise_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tick));

    assert_silence_blocks_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (!flag && !present) |=> !flag);

    assert_presence_keeps_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (flag && present) |=> flag);

    assert_zero_code_release_R6: assert property (@(posedge clk) disable iff (rst)
        (flag && !present && delay_code == 3'd0) |=> !flag);

    assert_timed_fall_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(flag) && $past(delay_code) != 3'd0) |-> $past(tick));

endmodule

bind audio_activity_flag audio_activity_flag_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .delay_code(delay_code),
    .present   (present),
    .flag      (flag)
);

// File: tb/audio_activity_flag_test.sv
module audio_activity_flag_test;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 16;
    localparam int TPS = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                tick = 1'b0;
    logic signed [W-1:0] left_smp = '0;
    logic signed [W-1:0] right_smp = '0;
    logic [W-1:0]        threshold = '0;
    logic [2:0]          delay_code = '0;
    logic                flag;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    bit exp_flag = 1'b0;
    int exp_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_activity_flag #(.W(W), .TPS(TPS)) uut (
        .clk(clk), .rst(rst), .tick(tick),
        .left_smp(left_smp), .right_smp(right_smp),
        .threshold(threshold), .delay_code(delay_code), .flag(flag)
    );

    function automatic int magf(input logic signed [W-1:0] v);
        return (v < 0) ? -int'(v) : int'(v);
    endfunction

    function automatic int hold_ticks(input logic [2:0] c);
        return (c == 3'd0) ? 0 : (int'(c) + 1) * 30 * TPS;
    endfunction

    task automatic check(input bit got, input bit want, input string req);
        compared++;
        if (got !== want) begin
            mismatched++;
            $display("FAIL %s: flag=%0b expected %0b at %0t", req, got, want, $time);
        end
    endtask

    task automatic cyc(input logic signed [W-1:0] l, input logic signed [W-1:0] r,
                       input logic [W-1:0] th, input logic [2:0] c, input bit tk,
                       input string req);
        bit pres, nf;
        int nc;
        @(negedge clk);
        left_smp = l; right_smp = r; threshold = th; delay_code = c; tick = tk;
        pres = (magf(l) > int'(th)) || (magf(r) > int'(th));
        nf = exp_flag; nc = exp_cnt;
        if (!exp_flag) begin
            if (!pres) nc = 0;
            else if (tk) begin
                if (exp_cnt == TPS - 1) begin nf = 1'b1; nc = 0; end
                else nc = exp_cnt + 1;
            end
        end else begin
            if (pres) nc = 0;
            else if (c == 3'd0) begin nf = 1'b0; nc = 0; end
            else if (tk) begin
                if (exp_cnt == hold_ticks(c) - 1) begin nf = 1'b0; nc = 0; end
                else nc = exp_cnt + 1;
            end
        end
        @(posedge clk); #1;
        exp_flag = nf; exp_cnt = nc;
        check(flag, exp_flag, req);
    endtask

    task automatic run(input int n, input logic signed [W-1:0] l, input logic signed [W-1:0] r,
                       input logic [W-1:0] th, input logic [2:0] c, input bit tk,
                       input string req);
        for (int i = 0; i < n; i++) cyc(l, r, th, c, tk, req);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        repeat (3) @(posedge clk);
        #1;
        check(flag, 1'b0, "R1");
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check(flag, 1'b0, "R1");

        // R2: equal to threshold is silence
        run(20, 16'sd100, 16'sd0, 16'd100, 3'd0, 1'b1, "R2");
        check(flag, 1'b0, "R2");
        // R3: negative right sample above threshold raises after TPS ticks
        run(TPS - 1, 16'sd0, -16'sd101, 16'd100, 3'd0, 1'b1, "R3");
        check(flag, 1'b0, "R3");
        run(1, 16'sd0, -16'sd101, 16'd100, 3'd0, 1'b1, "R3");
        check(flag, 1'b1, "R3");
        // R6: code zero immediate release
        run(1, 16'sd0, 16'sd0, 16'd100, 3'd0, 1'b1, "R6");
        check(flag, 1'b0, "R6");
        // R2: most negative sample over maximum positive threshold
        run(TPS, -16'sd32768, 16'sd0, 16'd32767, 3'd0, 1'b1, "R2");
        check(flag, 1'b1, "R2");
        run(1, 16'sd0, 16'sd0, 16'd32767, 3'd0, 1'b0, "R6");
        check(flag, 1'b0, "R6");
        // R4: gap restarts qualification
        run(TPS - 1, 16'sd500, 16'sd0, 16'd10, 3'd1, 1'b1, "R4");
        run(1, 16'sd3, 16'sd0, 16'd10, 3'd1, 1'b1, "R4");
        run(TPS - 1, 16'sd500, 16'sd0, 16'd10, 3'd1, 1'b1, "R4");
        check(flag, 1'b0, "R4");
        run(1, 16'sd500, 16'sd0, 16'd10, 3'd1, 1'b1, "R4");
        check(flag, 1'b1, "R4");
        // R5: code 1, 60 s
        run(hold_ticks(3'd1) - 1, 16'sd0, 16'sd0, 16'd10, 3'd1, 1'b1, "R5");
        check(flag, 1'b1, "R5");
        run(1, 16'sd0, 16'sd0, 16'd10, 3'd1, 1'b1, "R5");
        check(flag, 1'b0, "R5");
        // R8: no ticks, no rise
        run(50, 16'sd900, 16'sd900, 16'd10, 3'd7, 1'b0, "R8");
        check(flag, 1'b0, "R8");
        run(TPS, 16'sd900, 16'sd900, 16'd10, 3'd7, 1'b1, "R3");
        check(flag, 1'b1, "R3");
        // R8: no ticks, no release for code 7
        run(2000, 16'sd0, 16'sd0, 16'd10, 3'd7, 1'b0, "R8");
        check(flag, 1'b1, "R8");
        run(hold_ticks(3'd7) - 1, 16'sd0, 16'sd0, 16'd10, 3'd7, 1'b1, "R5");
        check(flag, 1'b1, "R5");
        run(1, 16'sd0, 16'sd0, 16'd10, 3'd7, 1'b1, "R5");
        check(flag, 1'b0, "R5");
        // R7: audio during countdown restarts it
        run(TPS, 16'sd0, 16'sd77, 16'd10, 3'd2, 1'b1, "R3");
        run(300, 16'sd0, 16'sd0, 16'd10, 3'd2, 1'b1, "R7");
        run(1, 16'sd0, -16'sd77, 16'd10, 3'd2, 1'b1, "R7");
        check(flag, 1'b1, "R7");
        run(hold_ticks(3'd2) - 1, 16'sd0, 16'sd0, 16'd10, 3'd2, 1'b1, "R7");
        check(flag, 1'b1, "R7");
        run(1, 16'sd0, 16'sd0, 16'd10, 3'd2, 1'b1, "R7");
        check(flag, 1'b0, "R7");

        // random bursts, code changed only while audio is present
        for (int s = 0; s < 30; s++) begin
            logic [W-1:0] th;
            logic [2:0] c;
            int alen, slen;
            th = W'($urandom_range(0, 1000));
            c = 3'($urandom_range(0, 2));
            alen = $urandom_range(2, 20);
            slen = $urandom_range(1, 800);
            for (int i = 0; i < alen; i++) begin
                logic signed [W-1:0] a, b;
                a = W'(int'(th) + 1 + int'($urandom_range(0, 50)));
                if ($urandom_range(0, 1) == 1) a = -a;
                b = W'($urandom_range(0, int'(th)));
                if ($urandom_range(0, 1) == 1) cyc(a, b, th, c, 1'($urandom_range(0, 1)), "R2");
                else                           cyc(b, a, th, c, 1'($urandom_range(0, 1)), "R3");
            end
            for (int i = 0; i < slen; i++) begin
                logic signed [W-1:0] a, b;
                a = W'($urandom_range(0, int'(th)));
                b = W'($urandom_range(0, int'(th)));
                if ($urandom_range(0, 1) == 1) a = -a;
                cyc(a, b, th, c, 1'($urandom_range(0, 1)), "R5");
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule